// File: doc/BRIEF.md
# Branch Target Landing Checker

This block decides, for every retired instruction, whether control arrived at a legal landing point after an indirect jump into or inside a guarded code page. It keeps a 2-bit branch-type state that records what kind of indirect transfer just happened. When the next instruction sits in a guarded page, that state is nonzero, the decoder says the instruction is not a compatible landing, and the core is not halted, the block raises a fault request for one cycle. The request comes with the low 52 bits of the offending instruction address.

The branch-type state is written when each instruction retires. Indirect jumps, calls and returns load a code that the decoder supplies. Landing-pad instructions load a second supplied code. Every other instruction clears the state to zero. An exception return can overwrite the state with a saved value. The check works only in 64-bit execution state. A build parameter removes the whole feature, and the block then has no effect at all.

Top module: `btarget_guard`

## Requirements
- R1: One cycle after a retiring instruction (`instr_valid`=1) in 64-bit state (`exec64`=1) with `in_guarded`=1, `bt_state`≠00, `bt_compat`=0 and `halted`=0, `fault_req` is 1.
- R2: `fault_req` is a registered pulse. It is 0 in every cycle that does not follow a cycle in which R1's condition held.
- R3: When a fault is raised, `fault_addr` equals bits 51:0 of `pc` from the faulting instruction. At all other times it keeps its last value.
- R4: In 64-bit state, a retiring instruction that is neither indirect (`is_indirect`) nor a landing pad (`is_landing`) sets `bt_state` to 00 at the next edge.
- R5: A retiring indirect branch, call or return loads `indirect_bt` into `bt_state`. This has priority over `is_landing`.
- R6: A retiring landing-pad instruction that is not indirect loads `landing_bt` into `bt_state`.
- R7: `eret_load`=1 loads `eret_bt` into `bt_state` at the next edge. This has priority over any retiring instruction in the same cycle.
- R8: With `exec64`=0, no fault is raised, and a retiring instruction sets `bt_state` to 00 whatever its kind.
- R9: In a cycle with neither `instr_valid` nor `eret_load`, `bt_state` keeps its value.
- R10: Reset (active-low `rst_n`) sets `bt_state` to 00, `fault_req` to 0 and `fault_addr` to 0.
- R11: With `FEATURE_EN`=0, `bt_state` and `fault_req` stay at 0 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | An instruction retires this cycle |
| exec64 | input | 1 | Core is in 64-bit execution state |
| in_guarded | input | 1 | Instruction was fetched from a guarded page |
| bt_compat | input | 1 | Decoder judged the instruction a compatible landing |
| halted | input | 1 | Core is in halted debug state |
| pc | input | ADDR_W | Address of the retiring instruction |
| is_indirect | input | 1 | Instruction is an indirect branch, call or return |
| is_landing | input | 1 | Instruction is a landing-pad instruction |
| indirect_bt | input | 2 | Next branch-type code from an indirect transfer |
| landing_bt | input | 2 | Next branch-type code from a landing pad |
| eret_load | input | 1 | Exception return restores a saved branch type |
| eret_bt | input | 2 | Saved branch-type value |
| bt_state | output | 2 | Current branch-type state |
| fault_req | output | 1 | One-cycle landing fault request |
| fault_addr | output | FAULT_W | Faulting address bits 51:0 |

## Verification
The assertions check several rules on every cycle. A fault pulse must always trace back to a retiring, guarded, incompatible and unhalted instruction with a nonzero state. The captured address must match that instruction's address and then stay unchanged. Each way of updating the state (clear, indirect load, landing load, exception-return overwrite, 32-bit clear, idle hold) must give the right next value. Other behaviour only shows up in the bench's scenarios: the order in which priorities resolve over a sequence of instructions, reset in the middle of a run, and the build in which the feature is compiled out.

// File: rtl/btg_pkg.sv
package btg_pkg;
   localparam int BT_W = 2;
   typedef logic [BT_W-1:0] btype_t;
   localparam btype_t BT_NONE = '0;
endpackage

// File: rtl/btg_check.sv
module btg_check
   import btg_pkg::*;
(
   input  logic   instr_valid,
   input  logic   exec64,
   input  logic   in_guarded,
   input  logic   bt_compat,
   input  logic   halted,
   input  btype_t bt_cur,
   output logic   violation
);
   always_comb begin
      violation = instr_valid && exec64 && in_guarded && (bt_cur != BT_NONE)
                  && !bt_compat && !halted;
   end
endmodule

// File: rtl/btg_state.sv
module btg_state
   import btg_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   instr_valid,
   input  logic   exec64,
   input  logic   is_indirect,
   input  logic   is_landing,
   input  btype_t indirect_bt,
   input  btype_t landing_bt,
   input  logic   eret_load,
   input  btype_t eret_bt,
   output btype_t bt_q
);
   btype_t bt_nxt;

   always_comb begin
      bt_nxt = bt_q;
      if (eret_load)             bt_nxt = eret_bt;
      else if (instr_valid) begin
         if (!exec64)            bt_nxt = BT_NONE;
         else if (is_indirect)   bt_nxt = indirect_bt;
         else if (is_landing)    bt_nxt = landing_bt;
         else                    bt_nxt = BT_NONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bt_q <= BT_NONE;
      else        bt_q <= bt_nxt;
   end

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !eret_load && exec64 && !is_indirect && !is_landing) |=> (bt_q == BT_NONE));
   assert_indirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !eret_load && exec64 && is_indirect) |=> (bt_q == $past(indirect_bt)));
   assert_landing_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !eret_load && exec64 && !is_indirect && is_landing) |=> (bt_q == $past(landing_bt)));
   assert_eret_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eret_load |=> (bt_q == $past(eret_bt)));
   assert_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !eret_load && !exec64) |=> (bt_q == BT_NONE));
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!instr_valid && !eret_load) |=> $stable(bt_q));
endmodule

// File: rtl/btg_report.sv
module btg_report #(
   parameter int FAULT_W = 52
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               violation,
   input  logic [FAULT_W-1:0] pc_lo,
   output logic               fault_req,
   output logic [FAULT_W-1:0] fault_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_req  <= 1'b0;
         fault_addr <= '0;
      end else begin
         fault_req <= violation;
         if (violation) fault_addr <= pc_lo;
      end
   end

   assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !violation |=> !fault_req);
   assert_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fault_req |-> (fault_addr == $past(pc_lo)));
   assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !violation |=> $stable(fault_addr));
endmodule

// File: rtl/btarget_guard.sv
module btarget_guard
   import btg_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int FAULT_W    = 52,
   parameter bit FEATURE_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic               exec64,
   input  logic               in_guarded,
   input  logic               bt_compat,
   input  logic               halted,
   input  logic [ADDR_W-1:0]  pc,
   input  logic               is_indirect,
   input  logic               is_landing,
   input  logic [1:0]         indirect_bt,
   input  logic [1:0]         landing_bt,
   input  logic               eret_load,
   input  logic [1:0]         eret_bt,
   output logic [1:0]         bt_state,
   output logic               fault_req,
   output logic [FAULT_W-1:0] fault_addr
);
   localparam int HI_W = ADDR_W - FAULT_W;

   if (FAULT_W >= ADDR_W || FAULT_W < 1) begin : g_bad_width
      $error("btarget_guard: FAULT_W must be in 1..ADDR_W-1");
   end
   if (BT_W != 2) begin : g_bad_bt
      $error("btarget_guard: branch-type width must be 2");
   end

   logic [HI_W-1:0] unused_pc_hi;
   assign unused_pc_hi = pc[ADDR_W-1:FAULT_W];

   if (FEATURE_EN) begin : g_on
      btype_t bt_q;
      logic   violation;

      btg_check u_check (
         .instr_valid(instr_valid), .exec64(exec64), .in_guarded(in_guarded),
         .bt_compat(bt_compat), .halted(halted), .bt_cur(bt_q),
         .violation(violation)
      );

      btg_state u_state (
         .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .exec64(exec64),
         .is_indirect(is_indirect), .is_landing(is_landing),
         .indirect_bt(indirect_bt), .landing_bt(landing_bt),
         .eret_load(eret_load), .eret_bt(eret_bt), .bt_q(bt_q)
      );

      btg_report #(.FAULT_W(FAULT_W)) u_report (
         .clk(clk), .rst_n(rst_n), .violation(violation),
         .pc_lo(pc[FAULT_W-1:0]), .fault_req(fault_req), .fault_addr(fault_addr)
      );

      assign bt_state = bt_q;

      assert_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
         fault_req |-> $past(instr_valid && exec64 && in_guarded && !bt_compat
                             && !halted && (bt_state != 2'b00)));
      assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !exec64 |=> !fault_req);
   end else begin : g_off
      logic unused_in;
      assign unused_in = ^{clk, rst_n, instr_valid, exec64, in_guarded, bt_compat,
                           halted, pc[FAULT_W-1:0], is_indirect, is_landing,
                           indirect_bt, landing_bt, eret_load, eret_bt};
      assign bt_state   = 2'b00;
      assign fault_req  = 1'b0;
      assign fault_addr = '0;
   end
endmodule

// File: tb/test_btarget_guard.sv
`timescale 1ns/1ps
module test_btarget_guard;
   localparam int ADDR_W  = 64;
   localparam int FAULT_W = 52;
   localparam int NV      = 18;
   // fields: eret, eret_bt[2], valid, x64, guard, compat, halt, ind, land, ind_bt[2], land_bt[2], exp_bt[2], exp_fault
   localparam logic [16:0] VEC [NV] = '{
      17'b1_11_0_0_0_0_0_0_0_00_00_11_0,  // R7 restore 11
      17'b0_00_1_1_1_0_0_0_0_00_00_00_1,  // R1 fault, R4 clear
      17'b0_00_1_1_1_0_0_0_0_00_00_00_0,  // R1 state zero, no fault
      17'b0_00_1_1_1_0_0_1_0_01_00_01_0,  // R5
      17'b0_00_1_1_1_1_0_0_1_00_00_00_0,  // R6 compatible landing
      17'b0_00_1_1_1_0_0_1_0_10_00_10_0,  // R5
      17'b0_00_1_1_1_0_1_0_0_00_00_00_0,  // R1 halted blocks
      17'b0_00_1_1_1_0_0_1_0_11_00_11_0,  // R5
      17'b0_00_1_1_0_0_0_0_0_00_00_00_0,  // R1 unguarded
      17'b0_00_1_1_1_0_0_1_0_10_00_10_0,  // R5
      17'b0_00_1_0_1_0_0_0_0_00_00_00_0,  // R8 32-bit
      17'b1_01_0_0_0_0_0_0_0_00_00_01_0,  // R7
      17'b0_00_0_1_1_0_0_0_0_00_00_01_0,  // R9 idle hold
      17'b0_00_1_1_1_0_0_1_1_10_01_10_1,  // R5 priority, R1 fault
      17'b0_00_1_1_1_0_0_0_1_00_11_11_1,  // R6, R2 back-to-back
      17'b1_00_1_1_1_1_0_1_0_11_00_00_0,  // R7 priority
      17'b0_00_1_1_1_0_0_0_0_00_00_00_0,  // R4
      17'b0_00_1_0_1_0_0_1_0_11_00_00_0   // R8 indirect in 32-bit
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic instr_valid = 0, exec64 = 0, in_guarded = 0, bt_compat = 0, halted = 0;
   logic [ADDR_W-1:0] pc = '0;
   logic is_indirect = 0, is_landing = 0, eret_load = 0;
   logic [1:0] indirect_bt = 0, landing_bt = 0, eret_bt = 0;
   logic [1:0] bt_state, off_bt;
   logic fault_req, off_fault;
   logic [FAULT_W-1:0] fault_addr, off_addr;
   int errors = 0, checks = 0;
   logic [FAULT_W-1:0] exp_addr = '0;

   always #5 clk = ~clk;

   btarget_guard #(.ADDR_W(ADDR_W), .FAULT_W(FAULT_W)) i_btarget_guard (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .exec64(exec64),
      .in_guarded(in_guarded), .bt_compat(bt_compat), .halted(halted), .pc(pc),
      .is_indirect(is_indirect), .is_landing(is_landing), .indirect_bt(indirect_bt),
      .landing_bt(landing_bt), .eret_load(eret_load), .eret_bt(eret_bt),
      .bt_state(bt_state), .fault_req(fault_req), .fault_addr(fault_addr));

   btarget_guard #(.ADDR_W(ADDR_W), .FAULT_W(FAULT_W), .FEATURE_EN(1'b0)) i_off (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .exec64(exec64),
      .in_guarded(in_guarded), .bt_compat(bt_compat), .halted(halted), .pc(pc),
      .is_indirect(is_indirect), .is_landing(is_landing), .indirect_bt(indirect_bt),
      .landing_bt(landing_bt), .eret_load(eret_load), .eret_bt(eret_bt),
      .bt_state(off_bt), .fault_req(off_fault), .fault_addr(off_addr));

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      {instr_valid, exec64, in_guarded, bt_compat, halted} = '0;
      {is_indirect, is_landing, eret_load, indirect_bt, landing_bt, eret_bt} = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R10 reset bt_state", bt_state, 0);
      chk("R10 reset fault_req", fault_req, 0);
      chk("R10 reset fault_addr", fault_addr, 0);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {eret_load, eret_bt, instr_valid, exec64, in_guarded, bt_compat, halted,
          is_indirect, is_landing, indirect_bt, landing_bt} = VEC[i][16:3];
         pc = 64'hFEDC_BA98_7654_0000 + 64'(i) * 4;
         if (VEC[i][0]) exp_addr = pc[FAULT_W-1:0];
         @(posedge clk);
         #2;
         chk($sformatf("R4 R5 R6 R7 R8 R9 bt_state vec %0d", i), bt_state, VEC[i][2:1]);
         chk($sformatf("R1 R2 R8 fault_req vec %0d", i), fault_req, VEC[i][0]);
         chk($sformatf("R3 fault_addr vec %0d", i), fault_addr, exp_addr);
         chk($sformatf("R11 disabled outputs vec %0d", i), {off_bt, off_fault}, 0);
      end

      // R2: the pulse drops once the violation stops
      @(negedge clk) idle_inputs();
      @(posedge clk); #2;
      chk("R2 pulse ends", fault_req, 0);

      // R10: reset in the middle of a run clears nonzero state
      @(negedge clk) begin eret_load = 1; eret_bt = 2'b10; end
      @(posedge clk); #2;
      chk("R7 restore before reset", bt_state, 2'b10);
      @(negedge clk) begin idle_inputs(); rst_n = 1'b0; end
      #2;
      chk("R10 mid-run bt_state", bt_state, 0);
      chk("R10 mid-run fault_addr", fault_addr, 0);
      @(negedge clk) rst_n = 1'b1;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule